// File: doc/BRIEF.md
# Code-Selected Reference Clock Divider

This block divides a reference clock by one of eight fixed ratios and emits one
single-cycle pulse per divide period. That pulse is the comparison-frequency
tick for a phase detector. A 3-bit select code picks the ratio from a fixed
table. Seven of the ratios are powers of two, and one, 1160, is not. The ratio
cannot be loaded freely; only the eight table entries can be chosen.

A 12-bit down counter is loaded with the selected ratio minus one. It counts
down one step per clock. When it reaches zero, the block asserts the output
pulse for one cycle and reloads the counter from the current select code. The
ratio in force for the running period is held in a register and driven on an
output, so the selection can be observed. A change of the select code waits
for the next reload, so a period already under way is never cut short. An
undriven select, which reads as all ones, gives the largest ratio.

Top module: `refdiv_sel`

## Requirements
- R1: Select codes 0,1,2,3,4,5,6,7 (sel_i as an unsigned number) give ratios 8, 64, 128, 256, 512, 1024, 1160 and 2048 respectively, and ratio_o always shows one of these values.
- R2: After the first pulse, pulse_o is high for exactly one clock and then stays low for ratio−1 clocks, so consecutive pulses are exactly `ratio` clocks apart.
- R3: After reset is released, the first pulse appears on the ratio-th rising edge with reset low.
- R4: A clock edge with rst_i high drives pulse_o low and loads ratio_o with the ratio of the sel_i value present at that edge.
- R5: A change of sel_i in the middle of a period does not alter that period's length or ratio_o. The new ratio is latched in the same edge that raises pulse_o, and it governs the period that follows.
- R6: Select code 7 (all ones, the value an undriven select presents) divides by 2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 3 | Ratio select code |
| pulse_o | output | 1 | One-cycle terminal-count pulse, once per divide period |
| ratio_o | output | 12 | Ratio governing the current period |

## Verification
The assertions assume that reset is held for at least one clock edge before any output is judged. They also assume that sel_i is a clean synchronous signal and never X. They do not assume sel_i is stable: the period and ratio properties must hold even when the code moves in the middle of a period. The stimulus sets sel_i only on falling edges. It switches the code both right after a pulse and deep inside a period. Across the run it uses every code, including the all-ones default, and it asserts reset repeatedly under different codes.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int SEL_W   = 3;
    localparam int CNT_W   = 12;
    localparam int N_CODES = 1 << SEL_W;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Fixed ratio table: index is the select code.
    function automatic cnt_t ratio_of(input sel_t code);
        cnt_t r;
        case (code)
            3'd0:    r = cnt_t'(8);
            3'd1:    r = cnt_t'(64);
            3'd2:    r = cnt_t'(128);
            3'd3:    r = cnt_t'(256);
            3'd4:    r = cnt_t'(512);
            3'd5:    r = cnt_t'(1024);
            3'd6:    r = cnt_t'(1160);
            default: r = cnt_t'(2048);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refdiv_lut.sv
module refdiv_lut
    import refdiv_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = CNT_W
) (
    input  logic [SW-1:0] sel_i,
    output logic [CW-1:0] ratio_o,
    output logic [CW-1:0] preset_o
);
    always_comb begin
        ratio_o  = CW'(ratio_of(sel_t'(sel_i)));
        preset_o = ratio_o - CW'(1);
    end
endmodule

// File: rtl/refdiv_cnt.sv
module refdiv_cnt #(
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [CW-1:0] preset_i,
    output logic          wrap_o,
    output logic          pulse_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_zero;

    always_comb begin
        at_zero = (st_q.cnt == '0);
        st_d    = st_q;
        if (rst_i) begin
            st_d.cnt   = preset_i;
            st_d.pulse = 1'b0;
        end else if (at_zero) begin
            st_d.cnt   = preset_i;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt - CW'(1);
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign wrap_o  = at_zero & ~rst_i;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/refdiv_sel.sv
module refdiv_sel
    import refdiv_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = CNT_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [SW-1:0] sel_i,
    output logic          pulse_o,
    output logic [CW-1:0] ratio_o
);
    logic [CW-1:0] lut_ratio;
    logic [CW-1:0] lut_preset;
    logic          wrap;

    typedef struct packed {
        logic [CW-1:0] ratio;
    } top_state_t;

    top_state_t st_d, st_q;

    refdiv_lut #(.SW(SW), .CW(CW)) u_lut (
        .sel_i    (sel_i),
        .ratio_o  (lut_ratio),
        .preset_o (lut_preset)
    );

    refdiv_cnt #(.CW(CW)) u_cnt (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .preset_i (lut_preset),
        .wrap_o   (wrap),
        .pulse_o  (pulse_o)
    );

    // Active ratio follows the select only at reset or reload.
    always_comb begin
        st_d = st_q;
        if (rst_i || wrap) begin
            st_d.ratio = lut_ratio;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign ratio_o = st_q.ratio;
endmodule

// File: rtl/refdiv_sel_chk.sv
module refdiv_sel_chk #(
    parameter int SW = 3,
    parameter int CW = 12
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [SW-1:0] sel_i,
    input logic          pulse_o,
    input logic [CW-1:0] ratio_o
);
    logic [CW:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        gap_q <= '0;
        else if (pulse_o) gap_q <= (CW+1)'(1);
        else              gap_q <= gap_q + (CW+1)'(1);
    end

    AST_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(ratio_o) == 1) || (ratio_o == CW'(1160))); // R1

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o); // R2

    AST_PULSE_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> (gap_q == {1'b0, $past(ratio_o)})); // R2

    AST_NO_EARLY_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        !pulse_o |-> (gap_q < {1'b0, ratio_o})); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !pulse_o); // R4

    AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pulse_o && !$past(rst_i)) |-> $stable(ratio_o)); // R5

    logic unused_sel;
    assign unused_sel = ^sel_i;
endmodule

bind refdiv_sel refdiv_sel_chk #(.SW(SW), .CW(CW)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sel_i   (sel_i),
    .pulse_o (pulse_o),
    .ratio_o (ratio_o)
);

// File: tb/refdiv_sel_tb.sv
module refdiv_sel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = 3'd7;
    logic        pulse;
    logic [11:0] ratio;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int tab [8] = '{8, 64, 128, 256, 512, 1024, 1160, 2048};

    // behavioural reference model
    int m_rem   = 0;
    int m_ratio = 0;
    bit m_pulse = 1'b0;

    always #10 clk = ~clk;

    refdiv_sel u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .sel_i   (sel),
        .pulse_o (pulse),
        .ratio_o (ratio)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_rem   = tab[sel] - 1;
            m_ratio = tab[sel];
            m_pulse = 1'b0;
        end else if (m_rem == 0) begin
            m_rem   = tab[sel] - 1;
            m_ratio = tab[sel];
            m_pulse = 1'b1;
        end else begin
            m_rem   = m_rem - 1;
            m_pulse = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R2, R5)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(pulse == m_pulse, "R2 model pulse", int'(pulse), int'(m_pulse));
            check(int'(ratio) == m_ratio, "R5 model ratio", int'(ratio), m_ratio);
        end
    end

    // negedges from now until pulse seen (inclusive)
    task automatic gap_to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse && n < 5000);
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst = 1'b1;
        sel = code;
        @(negedge clk);
        @(negedge clk);
        check(pulse == 1'b0, "R4 reset pulse", int'(pulse), 0);
        check(int'(ratio) == tab[code], "R4 reset ratio", int'(ratio), tab[code]);
        rst = 1'b0;
    endtask

    initial begin
        int n;
        // reset with the all-ones default code
        do_reset(3'd7);
        check(int'(ratio) == 2048, "R6 default ratio", int'(ratio), 2048);
        gap_to_pulse(n);
        check(n == 2048, "R6 default period", n, 2048);

        for (int c = 0; c < 8; c++) begin
            do_reset(3'(c));
            gap_to_pulse(n);
            check(n == tab[c], "R3 first pulse", n, tab[c]);
            check(int'(ratio) == tab[c], "R1 ratio value", int'(ratio), tab[c]);
            @(negedge clk);
            check(pulse == 1'b0, "R2 single cycle", int'(pulse), 0);
            gap_to_pulse(n);
            check(n == tab[c] - 1, "R2 period", n + 1, tab[c]);
        end

        // R5: switch 8 -> 64 inside a period
        do_reset(3'd0);
        gap_to_pulse(n);
        for (int k = 0; k < 3; k++) @(negedge clk);
        sel = 3'd1;
        @(negedge clk);
        check(int'(ratio) == 8, "R5 ratio held", int'(ratio), 8);
        gap_to_pulse(n);
        check(n == 4, "R5 period not shortened", n + 4, 8);
        check(int'(ratio) == 64, "R5 new ratio at reload", int'(ratio), 64);
        gap_to_pulse(n);
        check(n == 64, "R5 new period", n, 64);

        // R5: switch 2048 -> 8 deep inside, then 1160
        sel = 3'd7;
        gap_to_pulse(n);
        for (int k = 0; k < 1000; k++) @(negedge clk);
        sel = 3'd0;
        gap_to_pulse(n);
        check(n == 2048 - 1000, "R5 long period kept", n + 1000, 2048);
        sel = 3'd6;
        gap_to_pulse(n);
        check(n == 8, "R5 short period", n, 8);
        gap_to_pulse(n);
        check(n == 1160, "R1 ratio 1160 period", n, 1160);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule